// File: doc/BRIEF.md
# Four-Channel Nested-Loop DMA Controller

This block moves 32-bit words between memory locations for four independent channels. Each transfer is done as two accesses through one shared memory port: a read from the source address, then a write of that word to the destination address. Each channel has a descriptor with two nested loops. The inner (minor) loop moves a programmed number of bytes. The outer (major) loop counts how many minor loops remain. One activation runs exactly one minor loop. An activation comes from a software start pulse or from a link raised by a channel that has just ended a minor or major loop.

A shared arbiter chooses the next pending channel, in fixed-priority or round-robin order. The choice is made only at minor-loop boundaries, so a granted channel finishes its whole minor loop without interruption. When the major loop completes, the block can:
- apply a signed adjustment to both addresses;
- raise a sticky interrupt;
- activate a linked channel;
- fetch a fresh eight-word descriptor from memory (scatter/gather).

The controller is a five-state machine:
- `ST_IDLE`: waits for a grant. It takes the grant and moves to `ST_RD` if the channel's major count is non-zero; otherwise it drops the grant and stays in `ST_IDLE`.
- `ST_RD` (read request) → `ST_WR` when the read is accepted.
- `ST_WR` (write request) → `ST_RD` while words remain in the minor loop, or → `ST_MINOR_END` after the last word.
- `ST_MINOR_END`: decrements the major count and fires links and the interrupt. It then goes to `ST_SG_FETCH` if the major loop ended with scatter/gather enabled, otherwise back to `ST_IDLE`.
- `ST_SG_FETCH`: reads eight words, then returns to `ST_IDLE`.

Top module: `nld_dma`

## Requirements
- R1: Four channels each hold a descriptor written through `cfg_*`. The field codes for `cfg_sel` are:
  - 0: source byte address
  - 1: destination byte address
  - 2: offsets, with the source offset in bits 15:0 and the destination offset in bits 31:16, both signed bytes
  - 3: minor-loop byte count
  - 4: major count
  - 5: signed major-end adjustment
  - 6: scatter/gather byte address
  - 7: control, with bit0 interrupt enable, bit1 scatter/gather, bit2 minor-link enable, bits4:3 minor-link target, bit5 major-link enable, bits7:6 major-link target
- R2: Each word is read from the current source address, then written to the current destination address. `mem_req`, `mem_addr` and `mem_we` stay stable until `mem_ack`. Only one access is ever outstanding.
- R3: A minor loop moves byte count / 4 words. After each word, the source and destination addresses advance by their own signed offsets.
- R4: One activation runs exactly one minor loop. The major count then decrements by one and the channel idles until activated again.
- R5: Activating a channel whose major count is 0 causes no memory access.
- R6: At the end of a minor loop that leaves the major count non-zero, an enabled minor link activates the target channel. The final minor loop never fires it.
- R7: When the major count reaches 0, an enabled major link activates the target channel.
- R8: When the major count reaches 0, the adjustment is added to both the source and destination addresses.
- R9: With `rr_mode`=0, the highest-numbered pending channel is served first.
- R10: With `rr_mode`=1, the search for the next channel starts one above the last served channel and wraps around.
- R11: Once a channel is granted, it completes its whole minor loop before any other channel accesses memory.
- R12: When the major count reaches 0 and interrupt enable is set, that channel's `irq` bit sets. The bit holds until a 1 is written to the same bit of `irq_clr`. It never sets with interrupt enable clear.
- R13: When the major count reaches 0 with scatter/gather set, the block reads eight words at the scatter/gather address, +0 through +28. These are written in order into fields 0 to 7. The channel then waits for its next activation.
- R14: After reset, all `irq` bits are 0, there is no memory request, and every descriptor field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Field code (R1) |
| cfg_wdata | input | 32 | Field value |
| sw_start | input | 4 | Software activation pulse per channel |
| irq_clr | input | 4 | Write-one-to-clear for `irq` |
| rr_mode | input | 1 | 0 fixed priority, 1 round robin |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| irq | output | 4 | Sticky completion interrupts |

## Verification
A wrong loop counter shows up in the memory image within one activation: too many or too few destination words are written, or a channel stays silent after it is started. An address register that is off by an offset or an adjustment first shows up as a wrong word at the next write address. With the adjustment, that is the first word of the following major loop. Arbitration or rearbitration faults appear directly in the order of read addresses on the port within a few cycles of several simultaneous starts. Link, interrupt and scatter/gather faults appear as a missing or extra transfer by the target channel, or a wrong `irq` level, right after the source channel's minor loop ends.

// File: rtl/nld_dma_pkg.sv
package nld_dma_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_MINOR_END,
        ST_SG_FETCH
    } dma_state_e;

    // field codes; the scatter/gather fetch relies on this numbering
    typedef enum logic [2:0] {
        F_SRC    = 3'd0,
        F_DST    = 3'd1,
        F_OFFS   = 3'd2,
        F_NBYTES = 3'd3,
        F_CITER  = 3'd4,
        F_ADJ    = 3'd5,
        F_SGA    = 3'd6,
        F_CTRL   = 3'd7
    } dma_field_e;

endpackage

// File: rtl/nld_dma_arb.sv
module nld_dma_arb #(
    parameter int N_CH = 4,
    localparam int CHW = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pend,
    input  logic            rr_mode,
    input  logic            take,
    output logic            gnt_vld,
    output logic [CHW-1:0]  gnt_idx,
    output logic [N_CH-1:0] gnt_vec
);

    logic [CHW-1:0] last_q;
    logic [CHW-1:0] sel;

    always_comb begin
        int j;
        sel = '0;
        j   = 0;
        if (rr_mode) begin
            // walk from farthest to nearest so the nearest pending one wins
            for (int k = N_CH; k >= 1; k--) begin
                j = (int'(last_q) + k) % N_CH;
                if (pend[j]) sel = CHW'(j);
            end
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (pend[i]) sel = CHW'(i);
            end
        end
    end

    assign gnt_vld = |pend;
    assign gnt_idx = sel;
    assign gnt_vec = gnt_vld ? (N_CH'(1) << sel) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_q <= CHW'(N_CH - 1);
        else if (take) last_q <= sel;
    end

    p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec));

    p_gnt_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vec & ~pend) == '0);

endmodule

// File: rtl/nld_dma_chstat.sv
module nld_dma_chstat #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] sw_start,
    input  logic [N_CH-1:0] lnk_req,
    input  logic [N_CH-1:0] take_vec,
    input  logic [N_CH-1:0] irq_set,
    input  logic [N_CH-1:0] irq_clr,
    output logic [N_CH-1:0] pend,
    output logic [N_CH-1:0] irq
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                irq[i]  <= 1'b0;
            end else begin
                // a fresh activation in the grant cycle stays pending
                pend[i] <= (pend[i] & ~take_vec[i]) | sw_start[i] | lnk_req[i];
                irq[i]  <= irq_set[i] | (irq[i] & ~irq_clr[i]);
            end
        end

        p_irq_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !irq_clr[i]) |=> irq[i]);
    end

endmodule

// File: rtl/nld_dma_ctl.sv
module nld_dma_ctl
    import nld_dma_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CW   = 16,
    localparam int CHW   = $clog2(N_CH),
    localparam int CTRLW = 4 + 2 * CHW,
    localparam int WCW   = CW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              gnt_vld,
    input  logic [CHW-1:0]    gnt_idx,
    output logic              take,
    output logic [N_CH-1:0]   lnk_req,
    output logic [N_CH-1:0]   irq_set,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);

    // control field layout
    localparam int B_IE   = 0;
    localparam int B_SG   = 1;
    localparam int B_MINE = 2;
    localparam int B_MINT = 3;
    localparam int B_MAJE = 3 + CHW;
    localparam int B_MAJT = 4 + CHW;

    logic [WORD_W-1:0] src_q [N_CH];
    logic [WORD_W-1:0] dst_q [N_CH];
    logic [WORD_W-1:0] adj_q [N_CH];
    logic [WORD_W-1:0] sga_q [N_CH];
    logic [15:0]       soff_q[N_CH];
    logic [15:0]       doff_q[N_CH];
    logic [WCW-1:0]    wpl_q [N_CH];
    logic [CW-1:0]     cit_q [N_CH];
    logic [CTRLW-1:0]  ctl_q [N_CH];

    dma_state_e        state_q, state_d;
    logic [CHW-1:0]    cur_q;
    logic [WCW-1:0]    wcnt_q;
    logic [WORD_W-1:0] buf_q;
    logic [WORD_W-1:0] sg_base_q;
    logic [2:0]        sg_idx_q;

    logic              fw_en;
    logic [CHW-1:0]    fw_ch;
    logic [2:0]        fw_sel;
    logic [WORD_W-1:0] fw_data;
    logic              last_minor;
    logic [CTRLW-1:0]  cur_ctl;

    assign last_minor = (cit_q[cur_q] == CW'(1));
    assign cur_ctl    = ctl_q[cur_q];
    assign take       = (state_q == ST_IDLE) && gnt_vld;

    // single descriptor write port shared by software and the descriptor fetch
    always_comb begin
        if (state_q == ST_SG_FETCH) begin
            fw_en   = mem_ack;
            fw_ch   = cur_q;
            fw_sel  = sg_idx_q;
            fw_data = mem_rdata;
        end else begin
            fw_en   = cfg_we;
            fw_ch   = cfg_ch;
            fw_sel  = cfg_sel;
            fw_data = cfg_wdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (gnt_vld && cit_q[gnt_idx] != '0) state_d = ST_RD;
            ST_RD:        if (mem_ack) state_d = ST_WR;
            ST_WR:        if (mem_ack) state_d = (wcnt_q <= WCW'(1)) ? ST_MINOR_END : ST_RD;
            ST_MINOR_END: state_d = (last_minor && cur_ctl[B_SG]) ? ST_SG_FETCH : ST_IDLE;
            ST_SG_FETCH:  if (mem_ack && sg_idx_q == 3'd7) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = buf_q;
        lnk_req   = '0;
        irq_set   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_q[cur_q];
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q[cur_q];
            end
            ST_MINOR_END: begin
                if (last_minor) begin
                    irq_set[cur_q] = cur_ctl[B_IE];
                    if (cur_ctl[B_MAJE]) lnk_req[cur_ctl[B_MAJT +: CHW]] = 1'b1;
                end else if (cur_ctl[B_MINE]) begin
                    lnk_req[cur_ctl[B_MINT +: CHW]] = 1'b1;
                end
            end
            ST_SG_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = sg_base_q + {27'd0, sg_idx_q, 2'b00};
            end
            default: ;
        endcase
    end

    // descriptors and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CH; i++) begin
                src_q[i]  <= '0;
                dst_q[i]  <= '0;
                adj_q[i]  <= '0;
                sga_q[i]  <= '0;
                soff_q[i] <= '0;
                doff_q[i] <= '0;
                wpl_q[i]  <= '0;
                cit_q[i]  <= '0;
                ctl_q[i]  <= '0;
            end
            cur_q     <= '0;
            wcnt_q    <= '0;
            buf_q     <= '0;
            sg_base_q <= '0;
            sg_idx_q  <= '0;
        end else begin
            if (fw_en) begin
                unique case (dma_field_e'(fw_sel))
                    F_SRC:    src_q[fw_ch] <= fw_data;
                    F_DST:    dst_q[fw_ch] <= fw_data;
                    F_OFFS: begin
                        soff_q[fw_ch] <= fw_data[15:0];
                        doff_q[fw_ch] <= fw_data[31:16];
                    end
                    F_NBYTES: wpl_q[fw_ch] <= fw_data[CW-1:2];
                    F_CITER:  cit_q[fw_ch] <= fw_data[CW-1:0];
                    F_ADJ:    adj_q[fw_ch] <= fw_data;
                    F_SGA:    sga_q[fw_ch] <= fw_data;
                    F_CTRL:   ctl_q[fw_ch] <= fw_data[CTRLW-1:0];
                    default: ;
                endcase
            end
            unique case (state_q)
                ST_IDLE: if (take) begin
                    cur_q  <= gnt_idx;
                    wcnt_q <= wpl_q[gnt_idx];
                end
                ST_RD: if (mem_ack) buf_q <= mem_rdata;
                ST_WR: if (mem_ack) begin
                    src_q[cur_q] <= src_q[cur_q] + {{16{soff_q[cur_q][15]}}, soff_q[cur_q]};
                    dst_q[cur_q] <= dst_q[cur_q] + {{16{doff_q[cur_q][15]}}, doff_q[cur_q]};
                    wcnt_q       <= wcnt_q - WCW'(1);
                end
                ST_MINOR_END: begin
                    cit_q[cur_q] <= cit_q[cur_q] - CW'(1);
                    if (last_minor) begin
                        src_q[cur_q] <= src_q[cur_q] + adj_q[cur_q];
                        dst_q[cur_q] <= dst_q[cur_q] + adj_q[cur_q];
                        sg_base_q    <= sga_q[cur_q];
                        sg_idx_q     <= '0;
                    end
                end
                ST_SG_FETCH: if (mem_ack) sg_idx_q <= sg_idx_q + 3'd1;
                default: ;
            endcase
        end
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && mem_ack) |=> (mem_req && mem_we));

    p_keep_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q == ST_IDLE || $stable(cur_q)));

    p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cit_q[gnt_idx] == '0) |=> !mem_req);

endmodule

// File: rtl/nld_dma.sv
module nld_dma
    import nld_dma_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CW   = 16,
    localparam int CHW = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [N_CH-1:0]   sw_start,
    input  logic [N_CH-1:0]   irq_clr,
    input  logic              rr_mode,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [N_CH-1:0]   irq
);

    logic [N_CH-1:0] pend;
    logic [N_CH-1:0] gnt_vec;
    logic [N_CH-1:0] lnk_req;
    logic [N_CH-1:0] irq_set;
    logic [CHW-1:0]  gnt_idx;
    logic            gnt_vld;
    logic            take;

    nld_dma_arb #(.N_CH(N_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .rr_mode (rr_mode),
        .take    (take),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx),
        .gnt_vec (gnt_vec)
    );

    nld_dma_chstat #(.N_CH(N_CH)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_start (sw_start),
        .lnk_req  (lnk_req),
        .take_vec (take ? gnt_vec : '0),
        .irq_set  (irq_set),
        .irq_clr  (irq_clr),
        .pend     (pend),
        .irq      (irq)
    );

    nld_dma_ctl #(.N_CH(N_CH), .CW(CW)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .gnt_vld   (gnt_vld),
        .gnt_idx   (gnt_idx),
        .take      (take),
        .lnk_req   (lnk_req),
        .irq_set   (irq_set),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: tb/nld_dma_bench.sv
module nld_dma_bench;

    localparam int CLK_NS = 10;
    localparam int CT_IE  = 1;
    localparam int CT_SG  = 2;
    localparam int CT_MIN = 4;
    localparam int CT_MAJ = 32;

    // ch, src word, dst word, src offset bytes, dst offset bytes, words
    localparam int VEC[4][6] = '{
        '{0, 16,  64, 4,  4, 4},
        '{1, 24,  80, 4, -4, 3},
        '{2, 32,  96, 0,  4, 3},
        '{3, 40, 110, 8,  4, 3}
    };

    logic        clk, rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_ch;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [3:0]  sw_start, irq_clr, irq;
    logic        rr_mode;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [256];
    logic [31:0] log_a [64];
    int          nlog, acc_cnt, stc;
    logic        rdy, log_en;
    logic        bk_we;
    logic [7:0]  bk_addr;
    logic [31:0] bk_data;
    int          n_chk, n_fail;

    nld_dma u_nld_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .sw_start(sw_start),
        .irq_clr(irq_clr), .rr_mode(rr_mode), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE_0000 + 32'(i);
    endfunction

    initial clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    assign mem_ack   = mem_req & rdy;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        stc = stc + 1;
        rdy <= (stc % 3) != 2;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= (i < 64) ? pat(i) : 32'd0;
        end else begin
            if (bk_we) mem[bk_addr] <= bk_data;
            if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            if (mem_req && mem_ack) begin
                acc_cnt = acc_cnt + 1;
                if (log_en && !mem_we && nlog < 64) begin
                    log_a[nlog] = mem_addr;
                    nlog = nlog + 1;
                end
            end
        end
    end

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cfg(int ch, int sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(int ch, int sw, int dw, int so, int dof, int nb, int cit,
                        int adj, int sgw, int ctl);
        cfg(ch, 0, 32'(sw * 4));
        cfg(ch, 1, 32'(dw * 4));
        cfg(ch, 2, {16'(dof), 16'(so)});
        cfg(ch, 3, 32'(nb));
        cfg(ch, 4, 32'(cit));
        cfg(ch, 5, 32'(adj));
        cfg(ch, 6, 32'(sgw * 4));
        cfg(ch, 7, 32'(ctl));
    endtask

    task automatic start(logic [3:0] m);
        @(negedge clk); sw_start = m;
        @(negedge clk); sw_start = 4'd0;
    endtask

    task automatic clear(logic [3:0] m);
        @(negedge clk); irq_clr = m;
        @(negedge clk); irq_clr = 4'd0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic poke(int a, logic [31:0] d);
        @(negedge clk); bk_we = 1'b1; bk_addr = 8'(a); bk_data = d;
        @(negedge clk); bk_we = 1'b0;
    endtask

    task automatic wait_irq(int ch, string rq);
        int t;
        t = 0;
        while (!irq[ch] && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(irq[ch], rq, 32'(irq), 32'(1 << ch));
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base, a0;
        bit ok;
        logic [31:0] got, exp;
        n_chk = 0; n_fail = 0; nlog = 0; acc_cnt = 0; stc = 0;
        rdy = 1'b1; log_en = 1'b0; bk_we = 1'b0; bk_addr = '0; bk_data = '0;
        cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
        sw_start = '0; irq_clr = '0; rr_mode = 1'b0;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // reset state
        chk(irq == 4'd0, "R14 irq", 32'(irq), 0);
        chk(!mem_req, "R14 req", 32'(mem_req), 0);
        // descriptors cleared: a start finds major count 0
        start(4'b0001);
        idle(20);
        chk(acc_cnt == 0, "R5/R14 zero count", 32'(acc_cnt), 0);

        // vector table: one minor loop per channel
        for (int r = 0; r < 4; r++) begin
            int ch, nw;
            ch = VEC[r][0];
            nw = VEC[r][5];
            prog(ch, VEC[r][1], VEC[r][2], VEC[r][3], VEC[r][4], nw * 4, 1, 0, 0, CT_IE);
            start(4'(1 << ch));
            wait_irq(ch, "R12 table");
            ok = 1'b1; got = '0; exp = '0;
            for (int i = 0; i < nw; i++) begin
                if (mem[VEC[r][2] + i * VEC[r][4] / 4] != pat(VEC[r][1] + i * VEC[r][3] / 4)) begin
                    ok  = 1'b0;
                    got = mem[VEC[r][2] + i * VEC[r][4] / 4];
                    exp = pat(VEC[r][1] + i * VEC[r][3] / 4);
                end
            end
            chk(ok, "R1/R2/R3 table row", got, exp);
            clear(4'hF);
        end

        // R4: one minor loop per activation, R8 adjustment
        prog(0, 0, 128, 4, 4, 8, 3, 40, 0, CT_IE);
        start(4'b0001);
        idle(40);
        chk(mem[128] == pat(0) && mem[129] == pat(1), "R4 loop1", mem[129], pat(1));
        chk(mem[130] == 0 && irq == 0, "R4 one loop only", mem[130], 0);
        start(4'b0001);
        idle(40);
        chk(mem[131] == pat(3) && irq == 0, "R4 loop2", mem[131], pat(3));
        start(4'b0001);
        wait_irq(0, "R12 major end");
        chk(mem[133] == pat(5), "R4 loop3", mem[133], pat(5));
        a0 = acc_cnt;
        start(4'b0001);
        idle(30);
        chk(acc_cnt == a0, "R5 exhausted", 32'(acc_cnt), 32'(a0));
        cfg(0, 4, 1);
        start(4'b0001);
        idle(40);
        chk(mem[144] == pat(16) && mem[145] == pat(17), "R8 adjust", mem[144], pat(16));
        clear(4'b0001);
        chk(irq == 0, "R12 w1c", 32'(irq), 0);

        // R12: no interrupt without enable
        prog(1, 4, 150, 4, 4, 4, 1, 0, 0, 0);
        start(4'b0010);
        idle(30);
        chk(mem[150] == pat(4), "R3 no-ie copy", mem[150], pat(4));
        chk(irq == 0, "R12 disabled", 32'(irq), 0);

        // R6: minor link
        prog(0, 8, 160, 4, 4, 4, 2, 0, 0, CT_MIN | (1 << 3));
        prog(1, 9, 170, 4, 4, 4, 1, 0, 0, CT_IE);
        start(4'b0001);
        wait_irq(1, "R6 link fired");
        chk(mem[170] == pat(9), "R6 target copy", mem[170], pat(9));
        clear(4'hF);
        cfg(1, 1, 171 * 4);
        cfg(1, 4, 1);
        start(4'b0001);
        idle(60);
        chk(mem[161] == pat(9), "R6 final loop", mem[161], pat(9));
        chk(mem[171] == 0 && irq == 0, "R6 no link on final", mem[171], 0);

        // R7: major link
        prog(2, 10, 180, 4, 4, 4, 1, 0, 0, CT_MAJ | (3 << 6));
        prog(3, 11, 190, 4, 4, 4, 1, 0, 0, CT_IE);
        start(4'b0100);
        wait_irq(3, "R7 link fired");
        chk(mem[190] == pat(11), "R7 target copy", mem[190], pat(11));
        clear(4'hF);

        // R13: scatter/gather
        poke(200, 12 * 4);
        poke(201, 210 * 4);
        poke(202, 32'h0004_0004);
        poke(203, 8);
        poke(204, 1);
        poke(205, 0);
        poke(206, 0);
        poke(207, CT_IE);
        prog(1, 13, 220, 4, 4, 4, 1, 0, 200, CT_SG);
        start(4'b0010);
        idle(80);
        chk(mem[220] == pat(13) && irq == 0, "R13 first descriptor", mem[220], pat(13));
        start(4'b0010);
        wait_irq(1, "R13 loaded ctrl");
        chk(mem[210] == pat(12) && mem[211] == pat(13), "R13 loaded descriptor", mem[211], pat(13));
        clear(4'hF);

        // R9 / R11: fixed priority, no interleave
        rr_mode = 1'b0;
        for (int k = 0; k < 4; k++) prog(k, 20 + 2 * k, 230 + 2 * k, 4, 4, 8, 1, 0, 0, 0);
        base = nlog;
        log_en = 1'b1;
        start(4'hF);
        idle(100);
        log_en = 1'b0;
        ok = (nlog - base) == 8; got = 32'(nlog - base); exp = 8;
        for (int j = 0; j < 8 && ok; j++) begin
            exp = 32'((20 + 2 * (3 - j / 2) + j % 2) * 4);
            got = log_a[base + j];
            if (got != exp) ok = 1'b0;
        end
        chk(ok, "R9/R11 fixed order", got, exp);

        // R10: round robin after serving channel 1
        rr_mode = 1'b1;
        prog(1, 22, 240, 4, 4, 8, 1, 0, 0, 0);
        start(4'b0010);
        idle(40);
        for (int k = 0; k < 4; k++) prog(k, 20 + 2 * k, 246 + 2 * k, 4, 4, 8, 1, 0, 0, 0);
        base = nlog;
        log_en = 1'b1;
        start(4'hF);
        idle(100);
        log_en = 1'b0;
        ok = (nlog - base) == 8; got = 32'(nlog - base); exp = 8;
        for (int j = 0; j < 8 && ok; j++) begin
            exp = 32'((20 + 2 * ((2 + j / 2) % 4) + j % 2) * 4);
            got = log_a[base + j];
            if (got != exp) ok = 1'b0;
        end
        chk(ok, "R10 round robin order", got, exp);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule